// File: doc/BRIEF.md
# Fixed-Latency Multiply/Divide Unit

This unit performs the eight integer multiply, divide and remainder operations of a 32-bit RISC core. The host raises `start` for one cycle together with two operands and a 3-bit operation select. The unit captures all three on that edge and then counts cycles. It asserts `ready` for exactly one cycle, with the result on `result`, once the count for the operation class is reached. The count is 3 for the multiply class and 8 for the divide/remainder class. The count does not depend on the operand values.

While an operation is in flight and its result is not yet ready, `stall` is high. The host uses it to freeze its program counter and block its register-file writes. For a divide started in cycle T, `stall` is high in cycles T+1 through T+7 and `ready` is high in cycle T+8. The host then moves on in T+9. A multiply started in T stalls in T+1 and T+2 and is ready in T+3.

Top module: `fixlat_muldiv`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ready` and `stall` are 0 and `result` is 0.
- R2: `op` encodings are 000 MUL, 001 MULH, 010 MULHSU, 011 MULHU, 100 DIV, 101 DIVU, 110 REM and 111 REMU. MUL returns the low 32 bits of the product.
- R3: MULH, MULHSU and MULHU return the upper 32 bits of the 64-bit product. MULH treats both operands as signed. MULHSU treats `opa` as signed and `opb` as unsigned. MULHU treats both as unsigned.
- R4: DIV and DIVU return the quotient rounded toward zero, signed and unsigned respectively. REM and REMU return the matching remainder, which takes the sign of the dividend.
- R5: For a multiply-class operation started in cycle T, `stall` is 1 in cycles T+1 and T+2 and 0 in T+3, where `ready` is 1. `stall` and `ready` are never high together.
- R6: For a divide-class operation started in cycle T, `stall` is 1 in cycles T+1 through T+7 and 0 in T+8, where `ready` is 1.
- R7: `ready` is high for a single cycle per operation. `result` is 0 whenever `ready` is 0.
- R8: Division by zero returns all ones as the quotient (DIV, DIVU) and the dividend as the remainder (REM, REMU).
- R9: The signed overflow case, 0x80000000 divided by -1, returns 0x80000000 for DIV and 0 for REM.
- R10: Operands and select are captured at start. Input changes, and further `start` pulses, while an operation is in flight have no effect on its result or its timing.
- R11: Raising `rst` during an operation abandons it. No `ready` follows, and `stall` is 0 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 3 | Operation select (funct3 encoding) |
| opa | input | 32 | First operand (multiplicand or dividend) |
| opb | input | 32 | Second operand (multiplier or divisor) |
| ready | output | 1 | Result valid, one-cycle pulse |
| stall | output | 1 | Host freeze request while an operation is pending |
| result | output | 32 | Operation result, zero when not ready |

## Verification
A corrupted cycle counter or a wrong latched operation class shows at the ports as `ready` arriving early or late, or never arriving. The bench compares `ready` and `stall` with the expected pattern on every cycle after a start, so a timing fault is caught within at most eight cycles. Corrupted captured operands or select show only in the `result` value of the ready cycle. The bench therefore changes the inputs during flight, so that a capture fault is visible in that same cycle. A reset that leaves state behind shows as a stray `ready` or `stall` in the idle cycles after reset.

// File: rtl/fixlat_muldiv_pkg.sv
package fixlat_muldiv_pkg;

    parameter int XLEN = 32;

    typedef enum logic [2:0] {
        OP_MUL    = 3'b000,
        OP_MULH   = 3'b001,
        OP_MULHSU = 3'b010,
        OP_MULHU  = 3'b011,
        OP_DIV    = 3'b100,
        OP_DIVU   = 3'b101,
        OP_REM    = 3'b110,
        OP_REMU   = 3'b111
    } md_op_e;

    typedef struct packed {
        md_op_e            op;
        logic [XLEN-1:0]   a;
        logic [XLEN-1:0]   b;
    } md_req_t;

    function automatic logic op_is_div(input md_op_e op);
        return op[2];
    endfunction

    function automatic logic op_is_signed_div(input md_op_e op);
        return op[2] & ~op[0];
    endfunction

    function automatic logic op_wants_rem(input md_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/fixlat_seq.sv
module fixlat_seq
    import fixlat_muldiv_pkg::*;
#(
    parameter int MUL_LAT = 3,
    parameter int DIV_LAT = 8,
    localparam int MAX_LAT = (DIV_LAT > MUL_LAT) ? DIV_LAT : MUL_LAT,
    localparam int CNT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  md_req_t          req_in,
    output md_req_t          req_q,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] target;

    always_comb begin
        if (op_is_div(req_q.op))
            target = CNT_W'(DIV_LAT);
        else
            target = CNT_W'(MUL_LAT);
    end

    assign done = busy && (cnt == target);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            req_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                cnt   <= CNT_W'(1);
                req_q <= req_in;
            end
        end else if (done) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/fixlat_mul.sv
module fixlat_mul
    import fixlat_muldiv_pkg::*;
(
    input  md_req_t          req,
    output logic [XLEN-1:0]  y
);

    localparam int PW = 2 * XLEN;

    logic          a_sx;
    logic          b_sx;
    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;
    logic [PW-1:0] prod;

    always_comb begin
        a_sx  = (req.op == OP_MULH || req.op == OP_MULHSU) ? req.a[XLEN-1] : 1'b0;
        b_sx  = (req.op == OP_MULH) ? req.b[XLEN-1] : 1'b0;
        a_ext = {{XLEN{a_sx}}, req.a};
        b_ext = {{XLEN{b_sx}}, req.b};
        prod  = a_ext * b_ext;
        if (req.op == OP_MUL)
            y = prod[XLEN-1:0];
        else
            y = prod[PW-1:XLEN];
    end

endmodule

// File: rtl/fixlat_div.sv
module fixlat_div
    import fixlat_muldiv_pkg::*;
(
    input  md_req_t          req,
    output logic [XLEN-1:0]  y
);

    logic            sgn;
    logic            a_neg;
    logic            b_neg;
    logic [XLEN-1:0] a_mag;
    logic [XLEN-1:0] b_mag;
    logic [XLEN-1:0] q_mag;
    logic [XLEN-1:0] r_mag;
    logic [XLEN-1:0] q_out;
    logic [XLEN-1:0] r_out;

    always_comb begin
        sgn   = op_is_signed_div(req.op);
        a_neg = sgn & req.a[XLEN-1];
        b_neg = sgn & req.b[XLEN-1];
        a_mag = a_neg ? (~req.a + 1'b1) : req.a;
        b_mag = b_neg ? (~req.b + 1'b1) : req.b;
        if (b_mag == '0) begin
            q_mag = '0;
            r_mag = '0;
        end else begin
            q_mag = a_mag / b_mag;
            r_mag = a_mag % b_mag;
        end
        if (req.b == '0) begin
            q_out = '1;
            r_out = req.a;
        end else begin
            q_out = (a_neg ^ b_neg) ? (~q_mag + 1'b1) : q_mag;
            r_out = a_neg ? (~r_mag + 1'b1) : r_mag;
        end
        y = op_wants_rem(req.op) ? r_out : q_out;
    end

endmodule

// File: rtl/fixlat_muldiv.sv
module fixlat_muldiv
    import fixlat_muldiv_pkg::*;
#(
    parameter int MUL_LAT = 3,
    parameter int DIV_LAT = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [31:0]     opa,
    input  logic [31:0]     opb,
    output logic            ready,
    output logic            stall,
    output logic [31:0]     result
);

    localparam int MAX_LAT = (DIV_LAT > MUL_LAT) ? DIV_LAT : MUL_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    md_req_t          req_in;
    md_req_t          req_q;
    logic             seq_busy;
    logic             seq_done;
    logic [CNT_W-1:0] seq_cnt;
    logic [XLEN-1:0]  mul_y;
    logic [XLEN-1:0]  div_y;

    always_comb begin
        req_in.op = md_op_e'(op);
        req_in.a  = opa;
        req_in.b  = opb;
    end

    fixlat_seq #(
        .MUL_LAT(MUL_LAT),
        .DIV_LAT(DIV_LAT)
    ) i_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .req_in (req_in),
        .req_q  (req_q),
        .busy   (seq_busy),
        .done   (seq_done),
        .cnt    (seq_cnt)
    );

    fixlat_mul i_mul (
        .req (req_q),
        .y   (mul_y)
    );

    fixlat_div i_div (
        .req (req_q),
        .y   (div_y)
    );

    assign ready  = seq_done;
    assign stall  = seq_busy & ~seq_done;
    assign result = seq_done ? (op_is_div(req_q.op) ? div_y : mul_y) : '0;

endmodule

// File: rtl/fixlat_muldiv_chk.sv
module fixlat_muldiv_chk
    import fixlat_muldiv_pkg::*;
#(
    parameter int MUL_LAT = 3,
    parameter int DIV_LAT = 8,
    localparam int MAX_LAT = (DIV_LAT > MUL_LAT) ? DIV_LAT : MUL_LAT,
    localparam int CNT_W   = $clog2(MAX_LAT + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             ready,
    input logic             stall,
    input logic [31:0]      result,
    input logic             busy,
    input logic [CNT_W-1:0] cnt,
    input md_req_t          req_q
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!ready && !stall && result == '0));

    assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    assert_result_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (result == '0));

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
        stall |-> !ready);

    assert_start_stalls_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> stall);

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt != '0 && cnt <= CNT_W'(MAX_LAT)));

    assert_hold_request_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(req_q));

    assert_div_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (ready && req_q.b == '0 && (req_q.op == OP_DIV || req_q.op == OP_DIVU))
            |-> (result == '1));

endmodule

bind fixlat_muldiv fixlat_muldiv_chk #(
    .MUL_LAT(MUL_LAT),
    .DIV_LAT(DIV_LAT)
) i_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .ready  (ready),
    .stall  (stall),
    .result (result),
    .busy   (seq_busy),
    .cnt    (seq_cnt),
    .req_q  (req_q)
);

// File: tb/test_fixlat_muldiv.sv
module test_fixlat_muldiv;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  op;
    logic [31:0] opa;
    logic [31:0] opb;
    logic        ready;
    logic        stall;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;

    fixlat_muldiv i_fixlat_muldiv (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .op     (op),
        .opa    (opa),
        .opb    (opb),
        .ready  (ready),
        .stall  (stall),
        .result (result)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] ax, bx, p;
        longint sa, sb;
        ax = {32'b0, a};
        bx = {32'b0, b};
        if (o == 3'b001 || o == 3'b010) ax = {{32{a[31]}}, a};
        if (o == 3'b001) bx = {{32{b[31]}}, b};
        p = ax * bx;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (o)
            3'b000: return p[31:0];
            3'b001, 3'b010, 3'b011: return p[63:32];
            3'b100: return (b == 0) ? 32'hFFFF_FFFF : 32'(sa / sb);
            3'b101: return (b == 0) ? 32'hFFFF_FFFF : a / b;
            3'b110: return (b == 0) ? a : 32'(sa % sb);
            default: return (b == 0) ? a : a % b;
        endcase
    endfunction

    task automatic pulse_start(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op = o; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Follows one operation cycle by cycle; first sample is in T+1.
    task automatic follow(input string req, input string lat_req, input logic [2:0] o,
                          input logic [31:0] a, input logic [31:0] b, input bit disturb);
        int lat;
        lat = o[2] ? 8 : 3;
        pulse_start(o, a, b);
        for (int k = 1; k <= lat; k++) begin
            check(lat_req, {31'b0, stall}, {31'b0, (k < lat)});
            check(lat_req, {31'b0, ready}, {31'b0, (k == lat)});
            if (k == lat) check(req, result, model(o, a, b));
            else check("R7", result, 32'h0);
            if (disturb) begin
                op = ~o; opa = ~a; opb = b + 32'd7; start = 1'b1;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R7", {31'b0, ready}, 32'h0);
        check("R7", {31'b0, stall}, 32'h0);
    endtask

    task automatic test_reset;
        check("R1", {30'b0, ready, stall}, 32'h0);
        check("R1", result, 32'h0);
    endtask

    task automatic test_mul;
        follow("R2", "R5", 3'b000, 32'd12345, 32'd6789, 0);
        follow("R2", "R5", 3'b000, 32'hFFFF_FFFD, 32'd7, 0);
        follow("R3", "R5", 3'b001, 32'hFFFF_FFFD, 32'd7, 0);
        follow("R3", "R5", 3'b001, 32'h8000_0000, 32'h8000_0000, 0);
        follow("R3", "R5", 3'b010, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        follow("R3", "R5", 3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    endtask

    task automatic test_div;
        follow("R4", "R6", 3'b100, 32'hFFFF_FFF9, 32'd2, 0);
        follow("R4", "R6", 3'b101, 32'hFFFF_FFF9, 32'd2, 0);
        follow("R4", "R6", 3'b110, 32'hFFFF_FFF9, 32'd2, 0);
        follow("R4", "R6", 3'b111, 32'd100, 32'd7, 0);
        follow("R4", "R6", 3'b110, 32'd7, 32'hFFFF_FFFE, 0);
    endtask

    task automatic test_div_zero;
        follow("R8", "R6", 3'b100, 32'd55, 32'd0, 0);
        follow("R8", "R6", 3'b101, 32'd55, 32'd0, 0);
        follow("R8", "R6", 3'b110, 32'hFFFF_FF00, 32'd0, 0);
        follow("R8", "R6", 3'b111, 32'd55, 32'd0, 0);
    endtask

    task automatic test_overflow;
        follow("R9", "R6", 3'b100, 32'h8000_0000, 32'hFFFF_FFFF, 0);
        follow("R9", "R6", 3'b110, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    endtask

    task automatic test_hold;
        follow("R10", "R10", 3'b101, 32'd1000, 32'd3, 1);
        follow("R10", "R10", 3'b000, 32'd40000, 32'd50000, 1);
    endtask

    task automatic test_abort;
        pulse_start(3'b100, 32'd99, 32'd9);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 10; k++) begin
            check("R11", {30'b0, ready, stall}, 32'h0);
            @(negedge clk);
        end
        follow("R11", "R11", 3'b000, 32'd3, 32'd5, 0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; op = 3'b0; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        test_reset;
        rst = 1'b0;
        @(negedge clk);
        test_reset;
        test_mul;
        test_div;
        test_div_zero;
        test_overflow;
        test_hold;
        test_abort;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule